// File: doc/BRIEF.md
# FMA Special-Operand NaN Resolver

This unit sits beside a double-precision fused multiply-add datapath and deals with every case in which at least one of the three operands is a NaN. The three operands are multiplicand A, multiplicand B and addend C. For such a case it produces the final 64-bit result and the exception flags itself. The unit also spots the infinity-times-zero product, because the correct response to a NaN addend depends on it. When no operand is a NaN, the unit only signals that the main arithmetic result should be used. In that case its result and flag outputs stay at zero.

An 8-bit policy word configures the unit. The two low bits select how an infinity-times-zero product combined with a NaN addend is answered. Bit 7 is a separate flag that suppresses the Invalid exception for that case. Bit 7 can be combined with any mode. By default the answer is registered, giving one cycle of latency. A parameter selects a purely combinational variant.

Top module: `fma_nan_resolver`

## Requirements
- R1: An operand is a NaN when its 11-bit exponent field (bits 62:52) is all ones and its 52-bit fraction is nonzero. `special_o` is high exactly when an accepted operation has at least one NaN operand. Otherwise `special_o` is low and `result_o` and `flags_o` are zero. This includes the infinity-times-zero product with a numeric addend.
- R2: With the default registered build, `out_valid`, `special_o`, `result_o` and `flags_o` reflect the operation presented with `in_valid` one clock earlier. After reset all outputs are zero.
- R3: When the input NaN is returned and several operands are NaNs, the unit returns the first NaN in the order A, then B, then C.
- R4: A returned NaN is made quiet by setting fraction bit 51. Its sign and all other payload bits are kept.
- R5: `flags_o[0]` (Invalid) is set whenever any operand is a signaling NaN, meaning fraction bit 51 is clear.
- R6: When the product is zero times infinity, in either operand order, and C is a NaN, Invalid is set unless policy bit 7 is set.
- R7: Policy bit 7 never masks the Invalid flag raised by a signaling NaN. For example, with policy 0x81, the inputs 0 × 0x7FF0000000000000 + 0x7FF000000000AAAA give 0x7FF800000000AAAA with flags 0x01. The same product with 0x7FF800000000AAAA as the addend gives 0x7FF800000000AAAA with flags 0x00.
- R8: Policy mode 2 (bits 1:0) answers the infinity-times-zero-plus-NaN case with the default NaN 0xFFF8000000000000. The modes affect no other NaN case.
- R9: Policy mode 3 returns the default NaN for that case when C is a quiet NaN. When C is a signaling NaN, it returns C made quiet.
- R10: Policy modes 0 and 1 return C made quiet for that case.
- R11: Policy bits 6:2 are ignored. `flags_o[5:1]`, where bit 5 is Precision, are always zero, since no special case is inexact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and policy are presented this cycle |
| op_a | input | 64 | Multiplicand A, binary64 |
| op_b | input | 64 | Multiplicand B, binary64 |
| op_c | input | 64 | Addend C, binary64 |
| policy | input | 8 | Bits 1:0 mode for the infinity-times-zero-plus-NaN case, bit 7 suppresses its Invalid flag |
| out_valid | output | 1 | An answer is present |
| special_o | output | 1 | The answer below replaces the main datapath result |
| result_o | output | 64 | Special-case result |
| flags_o | output | 6 | Exception flags, Invalid at bit 0, Precision at bit 5 |

## Verification
The latency and A-first properties assume the registered build. They also assume that the policy word and operands are only meaningful while `in_valid` is high. The bench drives `in_valid` low between bursts and holds it low throughout reset, so the one-cycle history the properties compare against always describes a real operation. The properties make no assumption about the encodings of the operands. The stimulus covers each operand class the resolver separates: numbers, infinities, zeros, and quiet and signaling NaNs with either sign. It covers all four modes with and without the suppress bit.

// File: rtl/fnr_pkg.sv
package fnr_pkg;

    // Position of the suppress-Invalid bit inside the policy word.
    localparam int POLICY_W    = 8;
    localparam int SUPPRESS_AT = 7;

    typedef enum logic [1:0] {
        IZ_UNSET   = 2'd0,
        IZ_NEVER   = 2'd1,
        IZ_ALWAYS  = 2'd2,
        IZ_IFQUIET = 2'd3
    } iz_mode_e;

    typedef struct packed {
        logic nan;
        logic snan;
        logic inf;
        logic zero;
    } opclass_t;

endpackage

// File: rtl/fnr_classify.sv
module fnr_classify #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] op_i,
    output fnr_pkg::opclass_t     cls_o
);
    localparam int DW = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;
    logic              exp_none;
    logic              frac_none;

    always_comb begin
        exp_f      = op_i[DW-2 -: EXP_W];
        frac_f     = op_i[FRAC_W-1:0];
        exp_ones   = &exp_f;
        exp_none   = ~|exp_f;
        frac_none  = ~|frac_f;
        cls_o.nan  = exp_ones & ~frac_none;
        cls_o.snan = exp_ones & ~frac_none & ~frac_f[FRAC_W-1];
        cls_o.inf  = exp_ones & frac_none;
        cls_o.zero = exp_none & frac_none;
    end
endmodule

// File: rtl/fnr_pick.sv
module fnr_pick #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int FLAG_W = 6
) (
    input  logic [EXP_W+FRAC_W:0]          opa_i,
    input  logic [EXP_W+FRAC_W:0]          opb_i,
    input  logic [EXP_W+FRAC_W:0]          opc_i,
    input  fnr_pkg::opclass_t              cla_i,
    input  fnr_pkg::opclass_t              clb_i,
    input  fnr_pkg::opclass_t              clc_i,
    input  logic [fnr_pkg::POLICY_W-1:0]   policy_i,
    output logic                           special_o,
    output logic [EXP_W+FRAC_W:0]          result_o,
    output logic [FLAG_W-1:0]              flags_o
);
    import fnr_pkg::*;

    localparam int DW = 1 + EXP_W + FRAC_W;
    localparam logic [DW-1:0] QUIET_BIT = DW'(1) << (FRAC_W - 1);
    localparam logic [DW-1:0] DFLT_NAN  =
        {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    iz_mode_e        mode;
    logic            suppress;
    logic            any_nan;
    logic            any_snan;
    logic            iz_nan;
    logic            use_dflt;
    logic            invalid;
    logic [DW-1:0]   chosen;

    always_comb begin
        // Mode is read with the suppress bit and unused bits masked away.
        mode     = iz_mode_e'(policy_i[1:0]);
        suppress = policy_i[SUPPRESS_AT];
        any_nan  = cla_i.nan | clb_i.nan | clc_i.nan;
        any_snan = cla_i.snan | clb_i.snan | clc_i.snan;
        iz_nan   = ((cla_i.inf & clb_i.zero) | (cla_i.zero & clb_i.inf)) & clc_i.nan;

        if (cla_i.nan)      chosen = opa_i | QUIET_BIT;
        else if (clb_i.nan) chosen = opb_i | QUIET_BIT;
        else                chosen = opc_i | QUIET_BIT;

        unique case (mode)
            IZ_ALWAYS:  use_dflt = iz_nan;
            IZ_IFQUIET: use_dflt = iz_nan & ~clc_i.snan;
            default:    use_dflt = 1'b0;
        endcase

        invalid   = any_snan | (iz_nan & ~suppress);
        special_o = any_nan;
        result_o  = !any_nan ? '0 : (use_dflt ? DFLT_NAN : chosen);
        flags_o   = '0;
        flags_o[0] = any_nan & invalid;
    end
endmodule

// File: rtl/fma_nan_resolver.sv
module fma_nan_resolver #(
    parameter int EXP_W   = 11,
    parameter int FRAC_W  = 52,
    parameter int FLAG_W  = 6,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [63:0]           op_a,
    input  logic [63:0]           op_b,
    input  logic [63:0]           op_c,
    input  logic [7:0]            policy,
    output logic                  out_valid,
    output logic                  special_o,
    output logic [63:0]           result_o,
    output logic [FLAG_W-1:0]     flags_o
);
    import fnr_pkg::*;

    localparam int DW = 1 + EXP_W + FRAC_W;

    typedef struct packed {
        logic              vld;
        logic              spc;
        logic [DW-1:0]     res;
        logic [FLAG_W-1:0] flg;
    } resp_t;

    logic [DW-1:0]     ops [3];
    opclass_t          cls [3];
    logic              pk_special;
    logic [DW-1:0]     pk_result;
    logic [FLAG_W-1:0] pk_flags;
    resp_t             resp_d;
    resp_t             resp_q;

    assign ops[0] = op_a[DW-1:0];
    assign ops[1] = op_b[DW-1:0];
    assign ops[2] = op_c[DW-1:0];

    for (genvar gi = 0; gi < 3; gi++) begin : g_cls
        fnr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .op_i  (ops[gi]),
            .cls_o (cls[gi])
        );
    end

    fnr_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .FLAG_W(FLAG_W)) u_pick (
        .opa_i     (ops[0]),
        .opb_i     (ops[1]),
        .opc_i     (ops[2]),
        .cla_i     (cls[0]),
        .clb_i     (cls[1]),
        .clc_i     (cls[2]),
        .policy_i  (policy),
        .special_o (pk_special),
        .result_o  (pk_result),
        .flags_o   (pk_flags)
    );

    always_comb begin
        resp_d     = '0;
        resp_d.vld = in_valid;
        if (in_valid && pk_special) begin
            resp_d.spc = 1'b1;
            resp_d.res = pk_result;
            resp_d.flg = pk_flags;
        end
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) resp_q <= '0;
            else        resp_q <= resp_d;
        end
    end else begin : g_comb
        assign resp_q = resp_d;
    end

    assign out_valid = resp_q.vld;
    assign special_o = resp_q.spc;
    assign result_o  = resp_q.res;
    assign flags_o   = resp_q.flg;
endmodule

// File: rtl/fnr_checker.sv
module fnr_checker #(
    parameter int EXP_W   = 11,
    parameter int FRAC_W  = 52,
    parameter int FLAG_W  = 6,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [63:0]       op_a,
    input logic [63:0]       op_b,
    input logic [63:0]       op_c,
    input logic [7:0]        policy,
    input logic              out_valid,
    input logic              special_o,
    input logic [63:0]       result_o,
    input logic [FLAG_W-1:0] flags_o
);
    localparam int DW = 1 + EXP_W + FRAC_W;

    logic armed_q;
    logic a_is_nan;
    logic a_is_snan;

    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign a_is_nan  = (&op_a[DW-2 -: EXP_W]) && (|op_a[FRAC_W-1:0]);
    assign a_is_snan = a_is_nan && !op_a[FRAC_W-1];

    a_r1_plain_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !special_o |-> (result_o == '0 && flags_o == '0));

    a_r1_special_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        special_o |-> out_valid);

    // R4: every special answer is a quiet NaN
    a_r4_answer_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        special_o |-> ((&result_o[DW-2 -: EXP_W]) && result_o[FRAC_W-1]));

    a_r11_upper_flags_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[FLAG_W-1:1] == '0);

    if (OUT_REG) begin : g_seq
        a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
            armed_q |-> (out_valid == $past(in_valid)));

        a_r3_a_first: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && $past(in_valid && a_is_nan)) |->
                (result_o == ($past(op_a) | (64'd1 << (FRAC_W - 1)))));

        a_r5_snan_invalid: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && $past(in_valid && a_is_snan)) |-> flags_o[0]);
    end
endmodule

bind fma_nan_resolver fnr_checker #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .FLAG_W(FLAG_W), .OUT_REG(OUT_REG)
) u_fnr_checker (.*);

// File: tb/fma_nan_resolver_bench.sv
module fma_nan_resolver_bench;

    localparam logic [63:0] ZERO = 64'h0000_0000_0000_0000;
    localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] SN   = 64'h7FF0_0000_0000_AAAA;
    localparam logic [63:0] QN   = 64'h7FF8_0000_0000_AAAA;
    localparam logic [63:0] DN   = 64'hFFF8_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0, op_b = '0, op_c = '0;
    logic [7:0]  policy = '0;
    logic        out_valid, special_o;
    logic [63:0] result_o;
    logic [5:0]  flags_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic        sp;
        logic [63:0] r;
        logic [5:0]  f;
        string       tag;
    } exp_t;

    exp_t sb [$];

    always #10 clk = ~clk;

    fma_nan_resolver u_fma_nan_resolver (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .policy(policy),
        .out_valid(out_valid), .special_o(special_o),
        .result_o(result_o), .flags_o(flags_o)
    );

    task automatic push(input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] c, input logic [7:0] pol,
                        input logic esp, input logic [63:0] eres,
                        input logic [5:0] eflg, input string tag);
        exp_t item;
        @(negedge clk);
        op_a = a; op_b = b; op_c = c; policy = pol; in_valid = 1'b1;
        item.sp = esp; item.r = eres; item.f = eflg; item.tag = tag;
        sb.push_back(item);
    endtask

    task automatic idle_check();
        @(negedge clk);
        in_valid = 1'b0;
        op_a = QN; op_b = QN; op_c = QN; policy = 8'h81;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || special_o !== 1'b0) begin
            errors++;
            $display("FAIL R2 idle: out_valid=%b special=%b expected 0 0", out_valid, special_o);
        end
    endtask

    // Monitor: pop and compare on every answer
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t e;
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected answer: got %h expected none", result_o);
            end else begin
                e = sb.pop_front();
                if (special_o !== e.sp || result_o !== e.r || flags_o !== e.f) begin
                    errors++;
                    $display("FAIL %s: got sp=%b r=%h f=%h expected sp=%b r=%h f=%h",
                             e.tag, special_o, result_o, flags_o, e.sp, e.r, e.f);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || special_o !== 1'b0 || result_o !== '0 || flags_o !== '0) begin
            errors++;
            $display("FAIL R2 reset: v=%b s=%b r=%h f=%h expected all zero",
                     out_valid, special_o, result_o, flags_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        push(ONE, ONE, ONE, 8'h81, 1'b0, ZERO, 6'h00, "R1 numeric");
        push(ZERO, PINF, ONE, 8'h02, 1'b0, ZERO, 6'h00, "R1 inf*0 numeric addend");
        push(ZERO, PINF, SN, 8'h81, 1'b1, QN, 6'h01, "R7 0*Inf+SNaN suppressed");
        push(ZERO, PINF, QN, 8'h81, 1'b1, QN, 6'h00, "R7 0*Inf+QNaN suppressed");
        push(ZERO, PINF, QN, 8'h01, 1'b1, QN, 6'h01, "R6 0*Inf+QNaN raises");
        push(PINF, ZERO, QN, 8'h01, 1'b1, QN, 6'h01, "R6 Inf*0 order");
        push(ZERO, PINF, QN, 8'h02, 1'b1, DN, 6'h01, "R8 mode always");
        push(ZERO, PINF, SN, 8'h82, 1'b1, DN, 6'h01, "R8 mode always SNaN");
        push(QN, ONE, ONE, 8'h02, 1'b1, QN, 6'h00, "R8 mode outside inf*0");
        push(ZERO, PINF, QN, 8'h83, 1'b1, DN, 6'h00, "R9 ifquiet quiet addend");
        push(ZERO, PINF, SN, 8'h03, 1'b1, QN, 6'h01, "R9 ifquiet signaling addend");
        push(ZERO, PINF, SN, 8'h00, 1'b1, QN, 6'h01, "R10 mode unset");
        push(PINF, ZERO, QN, 8'h80, 1'b1, QN, 6'h00, "R10 mode unset suppressed");
        push(64'h7FF8_0000_0000_0001, 64'h7FF0_0000_0000_0002, QN, 8'h01,
             1'b1, 64'h7FF8_0000_0000_0001, 6'h01, "R3 A before B");
        push(ONE, 64'hFFF8_0000_0000_0003, SN, 8'h01,
             1'b1, 64'hFFF8_0000_0000_0003, 6'h01, "R3 B before C");
        push(64'hFFF0_0000_0000_1234, ONE, ONE, 8'h00,
             1'b1, 64'hFFF8_0000_0000_1234, 6'h01, "R4 R5 negative SNaN quieted");
        push(ONE, ONE, SN, 8'h80, 1'b1, QN, 6'h01, "R5 SNaN addend not suppressed");
        push(ZERO, PINF, QN, 8'h7E, 1'b1, DN, 6'h01, "R11 upper policy bits ignored");
        push(PINF, ONE, QN, 8'h02, 1'b1, QN, 6'h00, "R8 no inf*0 no default");
        idle_check();
        push(ZERO, PINF, QN, 8'h7D, 1'b1, QN, 6'h01, "R11 mode never with junk bits");
        idle_check();
        repeat (3) @(negedge clk);

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2 missing answers: %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule